// File: doc/BRIEF.md
# Dual-Pipe Instruction Steering Unit

This block sits between instruction decode and two execution pipes, called X and Y. Each cycle it is offered two decoded instruction descriptors: a lead and the one that follows it, the trail. From these it decides whether both issue together, one into each pipe, or whether only the lead issues. For every issued instruction it reports the pipe it is sent to, and it reports how many instructions were consumed. Upstream uses this count to advance its queue. When only the lead issues, the trail becomes the lead of the next offer.

Pipe choice is normally an alternation. The unit holds one bit of state, the pipe used by the most recently issued instruction. An ordinary instruction is sent to the other pipe. Branch, floating-point and unpairable instructions are pinned to pipe X. Pairing is refused in these cases:
- the trail is pinned to X;
- the lead is unpairable;
- both instructions implicitly update the same register;
- the trail reads the lead's destination, unless at most one of the two is arithmetic and the operand sizes agree.

Operand execution, flags and memory are outside this block.

Top module: `dual_pipe_steer`

## Requirements
- R1: An ordinary-class lead (class code 0) is sent to the pipe opposite to the one used by the last issued instruction. Pipe code 0 is X and pipe code 1 is Y.
- R2: A lead of class branch (code 1) or floating-point (code 2) is always sent to pipe X.
- R3: A lead of class unpairable (code 3) is sent to pipe X and always issues alone (`take_cnt` = 1).
- R4: If the lead's valid destination register index equals the index of any valid source of the trail, the pair may issue together only if the two arithmetic bits are not both set and every such matching source has the same size code as the destination.
- R5: When pairing is refused, `take_cnt` is 1 and only `lead_pipe` is meaningful. The trail is not issued.
- R6: If the lead's and the trail's implicit-update masks share any set bit, the pair never issues together.
- R7: A trail that writes a register the lead reads, or writes the lead's destination, does not by that fact lose pairing.
- R8: A trail whose class is not ordinary (codes 1, 2, 3) never issues with the lead.
- R9: After reset the last-pipe memory holds Y, so the first ordinary instruction issued goes to X.
- R10: `take_cnt` is 0 while `rst` is high, while `issue_vld` is low, or while `hold` is high. In such a cycle the last-pipe memory keeps its value.
- R11: Descriptor layout, from MSB to LSB, 23 bits in total:
  - class [22:21];
  - arithmetic bit [20];
  - destination {valid, index[2:0], size[1:0]} at [19:14];
  - source 1 with the same shape at [13:8];
  - source 0 at [7:2];
  - implicit-update mask [1:0].
  Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit.
- R12: When two instructions issue, the trail goes to the pipe opposite the lead. The last-pipe memory then takes the trail's pipe. When one issues, it takes the lead's pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Lead and trail descriptors are valid |
| hold | input | 1 | Downstream stall; nothing issues |
| lead_desc | input | 23 | Descriptor of the older instruction |
| trail_desc | input | 23 | Descriptor of the younger instruction |
| take_cnt | output | 2 | Instructions consumed this cycle (0, 1, 2) |
| lead_pipe | output | 1 | Pipe for the lead (0 = X, 1 = Y) |
| trail_pipe | output | 1 | Pipe for the trail, valid when take_cnt is 2 |

## Verification
The hardest situation to reach is a read-after-write pair that sits on the boundary of the pairing rule. One case has matching sizes but both instructions arithmetic. Another has one arithmetic instruction but a size mismatch on only the second of two matching sources. A further difficulty is that the pipe state depends on the whole issue history, including cycles where the trail was refused. Directed offers build these exact operand combinations and walk the pipe state through refusals, stalls and pinned classes. A long random phase then draws register indices from a small set and sizes from two codes, so that matches and size conflicts arise often. A behavioural model checks every cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int REG_W = 3;
    localparam int NSRC  = 2;
    localparam int IMP_W = 2;

    typedef enum logic [1:0] {
        CL_PLAIN  = 2'd0,
        CL_BRANCH = 2'd1,
        CL_FLOAT  = 2'd2,
        CL_SOLO   = 2'd3
    } iclass_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_RSV = 2'd3
    } opsz_e;

    typedef enum logic {
        PIPE_X = 1'b0,
        PIPE_Y = 1'b1
    } pipe_e;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] idx;
        opsz_e            sz;
    } opnd_t;

    typedef struct packed {
        iclass_e               cls;
        logic                  arith;
        opnd_t                 dst;
        opnd_t [NSRC-1:0]      src;
        logic  [IMP_W-1:0]     imp;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    // Classes that may only enter pipe X
    function automatic logic x_only(iclass_e c);
        return c != CL_PLAIN;
    endfunction

    function automatic pipe_e other_pipe(pipe_e p);
        return (p == PIPE_X) ? PIPE_Y : PIPE_X;
    endfunction

endpackage

// File: rtl/steer_hazard.sv
module steer_hazard
    import steer_pkg::*;
(
    input  desc_t lead,
    input  desc_t trail,
    output logic  pair_ok
);

    logic [NSRC-1:0] raw_hit;
    logic [NSRC-1:0] size_bad;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign raw_hit[i]  = lead.dst.vld && trail.src[i].vld &&
                                 (lead.dst.idx == trail.src[i].idx);
            assign size_bad[i] = raw_hit[i] && (lead.dst.sz != trail.src[i].sz);
        end
    endgenerate

    logic class_ok;
    logic imp_clash;
    logic raw_ok;

    always_comb begin
        class_ok  = (lead.cls != CL_SOLO) && !x_only(trail.cls);
        imp_clash = |(lead.imp & trail.imp);
        raw_ok    = !(|raw_hit) ||
                    (!(lead.arith && trail.arith) && !(|size_bad));
        pair_ok   = class_ok && !imp_clash && raw_ok;
    end

endmodule

// File: rtl/steer_track.sv
module steer_track
    import steer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    paired,
    input  iclass_e lead_cls,
    output pipe_e   lead_pipe,
    output pipe_e   trail_pipe
);

    pipe_e last_q;

    always_comb begin
        lead_pipe  = x_only(lead_cls) ? PIPE_X : other_pipe(last_q);
        trail_pipe = other_pipe(lead_pipe);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PIPE_Y;
        end else if (adv) begin
            last_q <= paired ? trail_pipe : lead_pipe;
        end
    end

    // R9
    reset_y_chk: assert property (@(posedge clk) rst |=> last_q == PIPE_Y);

    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(last_q));

endmodule

// File: rtl/dual_pipe_steer.sv
module dual_pipe_steer
    import steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic              hold,
    input  logic [DESC_W-1:0] lead_desc,
    input  logic [DESC_W-1:0] trail_desc,
    output logic [1:0]        take_cnt,
    output logic              lead_pipe,
    output logic              trail_pipe
);

    desc_t ld;
    desc_t tr;
    logic  pair_ok;
    logic  go;
    pipe_e lp;
    pipe_e tp;

    assign ld = desc_t'(lead_desc);
    assign tr = desc_t'(trail_desc);
    assign go = issue_vld && !hold && !rst;

    steer_hazard u_hazard (
        .lead    (ld),
        .trail   (tr),
        .pair_ok (pair_ok)
    );

    steer_track u_track (
        .clk        (clk),
        .rst        (rst),
        .adv        (go),
        .paired     (pair_ok),
        .lead_cls   (ld.cls),
        .lead_pipe  (lp),
        .trail_pipe (tp)
    );

    always_comb begin
        take_cnt   = !go ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);
        lead_pipe  = lp;
        trail_pipe = tp;
    end

    // R2
    pinned_x_chk: assert property (@(posedge clk) disable iff (rst)
        (take_cnt != 2'd0 && (ld.cls == CL_BRANCH || ld.cls == CL_FLOAT))
        |-> lead_pipe == PIPE_X);

    // R3
    solo_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (take_cnt != 2'd0 && ld.cls == CL_SOLO)
        |-> (take_cnt == 2'd1 && lead_pipe == PIPE_X));

    // R6
    imp_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (take_cnt != 2'd0 && (ld.imp & tr.imp) != '0) |-> take_cnt == 2'd1);

    // R8
    trail_pinned_chk: assert property (@(posedge clk) disable iff (rst)
        (take_cnt != 2'd0 && tr.cls != CL_PLAIN) |-> take_cnt == 2'd1);

    // R12
    pair_split_chk: assert property (@(posedge clk) disable iff (rst)
        take_cnt == 2'd2 |-> lead_pipe != trail_pipe);

    // R1
    alternate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(take_cnt == 2'd1 && lead_pipe == PIPE_X) &&
         take_cnt != 2'd0 && ld.cls == CL_PLAIN) |-> lead_pipe == PIPE_Y);

endmodule

// File: tb/dual_pipe_steer_bench.sv
`timescale 1ns/1ps
module dual_pipe_steer_bench;
    import steer_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_vld = 1'b0;
    logic              hold = 1'b0;
    logic [DESC_W-1:0] lead_desc = '0;
    logic [DESC_W-1:0] trail_desc = '0;
    logic [1:0]        take_cnt;
    logic              lead_pipe;
    logic              trail_pipe;

    int checks = 0;
    int errors = 0;
    int m_last = 1;   // model: last pipe, 0 = X, 1 = Y

    always #4 clk = ~clk;

    dual_pipe_steer u_dual_pipe_steer (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .hold(hold),
        .lead_desc(lead_desc), .trail_desc(trail_desc),
        .take_cnt(take_cnt), .lead_pipe(lead_pipe), .trail_pipe(trail_pipe)
    );

    function automatic desc_t mk(int cls, int ar, int dr, int s0r, int imp);
        desc_t d;
        d = '0;
        d.cls = iclass_e'(cls[1:0]);
        d.arith = ar[0];
        d.dst.vld = (dr >= 0);
        d.dst.idx = (dr >= 0) ? dr[2:0] : 3'd0;
        d.dst.sz = SZ_32;
        d.src[0].vld = (s0r >= 0);
        d.src[0].idx = (s0r >= 0) ? s0r[2:0] : 3'd0;
        d.src[0].sz = SZ_32;
        d.imp = imp[1:0];
        return d;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(desc_t a, desc_t b, bit v, bit h, string tag);
        int tk, p0, p1, hit, bad;
        @(posedge clk); #1;
        lead_desc = a; trail_desc = b; issue_vld = v; hold = h;
        @(negedge clk);
        tk = 0; p0 = 0; p1 = 0;
        if (v && !h && !rst) begin
            p0 = (a.cls == CL_PLAIN) ? 1 - m_last : 0;
            p1 = 1 - p0;
            hit = 0; bad = 0;
            for (int s = 0; s < 2; s++) begin
                if (a.dst.vld && b.src[s].vld && a.dst.idx == b.src[s].idx) begin
                    hit = 1;
                    if (a.dst.sz != b.src[s].sz) bad = 1;
                end
            end
            if (a.cls == CL_SOLO || b.cls != CL_PLAIN || (a.imp & b.imp) != 0)
                tk = 1;
            else if (hit != 0 && (bad != 0 || (a.arith && b.arith)))
                tk = 1;
            else
                tk = 2;
        end
        check(tag, int'(take_cnt), tk, "take_cnt");
        if (tk > 0) check(tag, int'(lead_pipe), p0, "lead_pipe");
        if (tk == 2) check(tag, int'(trail_pipe), p1, "trail_pipe");
        if (tk == 1) m_last = p0;
        else if (tk == 2) m_last = p1;
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        desc_t solo, pl, a, b;
        solo = mk(3, 0, -1, -1, 0);
        pl   = mk(0, 0, -1, -1, 0);
        // R10: nothing issues during reset even when offered
        issue_vld = 1'b1;
        lead_desc = pl; trail_desc = pl;
        repeat (3) begin
            @(negedge clk);
            check("R10", int'(take_cnt), 0, "take_cnt in reset");
        end
        @(posedge clk); #1 rst = 1'b0; issue_vld = 1'b0;

        step(pl, solo, 1, 0, "R9");                    // first ordinary -> X
        step(pl, solo, 1, 0, "R1");                    // -> Y
        step(pl, solo, 1, 0, "R1");                    // -> X
        step(mk(1,0,-1,-1,0), solo, 1, 0, "R2");       // branch after X -> X
        step(mk(2,0,-1,-1,0), solo, 1, 0, "R2");       // float -> X
        step(pl, solo, 1, 0, "R1");                    // -> Y
        step(mk(1,0,-1,-1,0), solo, 1, 0, "R2");       // branch after Y -> X
        step(solo, pl, 1, 0, "R3");                    // alone in X
        // R4: raw, one arithmetic, same size -> pair
        step(mk(0,1,1,-1,0), mk(0,0,2,1,0), 1, 0, "R4");
        // R4/R5: raw both arithmetic -> refused
        step(mk(0,1,1,-1,0), mk(0,1,2,1,0), 1, 0, "R5");
        // R4/R5: size mismatch on source 1 only
        a = mk(0,0,4,-1,0);
        b = mk(0,0,5,4,0);
        b.src[1].vld = 1'b1; b.src[1].idx = 3'd4; b.src[1].sz = SZ_16;
        step(a, b, 1, 0, "R5");
        b.src[1].sz = SZ_32;
        step(a, b, 1, 0, "R4");
        // R6: shared implicit update
        step(mk(0,0,-1,-1,1), mk(0,0,-1,-1,1), 1, 0, "R6");
        step(mk(0,0,-1,-1,1), mk(0,0,-1,-1,2), 1, 0, "R6");
        // R7: WAR and WAW
        step(mk(0,1,-1,2,0), mk(0,1,2,-1,0), 1, 0, "R7");
        step(mk(0,1,3,-1,0), mk(0,1,3,-1,0), 1, 0, "R7");
        // R8: pinned trail
        step(pl, mk(1,0,-1,-1,0), 1, 0, "R8");
        step(pl, mk(2,0,-1,-1,0), 1, 0, "R8");
        step(pl, pl, 1, 0, "R12");
        // R10: idle and stall leave memory untouched
        step(pl, pl, 0, 0, "R10");
        step(pl, pl, 1, 1, "R10");
        step(pl, solo, 1, 0, "R10");

        // R11: random descriptors over the documented layout
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            desc_t ra, rb;
            r = $urandom;
            ra = desc_t'(r[DESC_W-1:0]);
            r = $urandom;
            rb = desc_t'(r[DESC_W-1:0]);
            ra.cls = ($urandom % 4 == 0) ? iclass_e'($urandom % 4) : CL_PLAIN;
            rb.cls = ($urandom % 4 == 0) ? iclass_e'($urandom % 4) : CL_PLAIN;
            ra.dst.idx = 3'($urandom % 3);
            ra.dst.sz = opsz_e'($urandom % 2);
            for (int s = 0; s < 2; s++) begin
                rb.src[s].idx = 3'($urandom % 3);
                rb.src[s].sz = opsz_e'($urandom % 2);
            end
            if ($urandom % 2 == 0) rb.imp = '0;
            step(ra, rb, ($urandom % 8) != 0, ($urandom % 10) == 0, "R11");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule